// File: doc/BRIEF.md
# I2S Playback Serializer with Underflow Policy

The block drains audio words from an internal transmit FIFO and shifts them out on a single serial data line. Timing comes from an outside clock generator as two single-cycle strobes in the system clock domain: `bit_stb` marks each bit-clock period and `frame_stb`, given together with a bit strobe, marks the first bit of a frame. A frame has two 32-bit channel slots. Samples are sent MSB first and padded with zeros. Framing is standard I2S or MSB-justified, and either channel can go first. The block handles mono and stereo, sample sizes from 8 to 24 bits, and a packed mode in which one 32-bit word holds both 16-bit samples of a frame.

If the FIFO has no word ready when a sample is due, the block applies a selectable underflow policy. It either keeps the last sample of that channel or sends silence. It also sets a sticky underrun flag, which can drive an interrupt line. A refill request stays high while the FIFO level is at or below a programmable threshold, so a DMA engine or the software can top the FIFO up in bursts.

Top module: `i2s_tx_serializer`

## Requirements
- R1: A write with `wr_en` high and the FIFO not full stores `wr_data`. The default depth is 16 words. `fifo_full` is high exactly when 16 words are held, and a write while full is dropped. Words leave in the order they were written.
- R2: `tx_req` is high whenever the number of held words is less than or equal to `thresh`.
- R3: Each slot is 32 bit strobes long. The sample goes out MSB first and every slot bit outside the sample is 0. `cfg_size` encodes the sample width as 0=8, 1=16, 2=18, 3=20 and 4=24 bits, and the reserved codes 5..7 act as 24 bits.
- R4: With `cfg_msbj`=0 (I2S), slot bit 0 is 0 and the sample MSB is on slot bit 1. With `cfg_msbj`=1 (MSB-justified), the MSB is on slot bit 0.
- R5: With `cfg_rfirst`=0 the first slot of a frame carries the left sample. With `cfg_rfirst`=1 it carries the right sample.
- R6: In stereo (`cfg_stereo`=1) without packing, each slot takes one FIFO word. Word bits [23:0] hold the sample right-aligned, and bits above the sample width are ignored.
- R7: In mono (`cfg_stereo`=0), one word is taken at the start of each frame and its sample is sent in both slots. `cfg_packed` has no effect in mono.
- R8: In packed stereo (`cfg_stereo`=1, `cfg_packed`=1), one word is taken per frame. Bits [15:0] are the left sample and bits [31:16] are the right sample, both 16 bits wide whatever `cfg_size` says.
- R9: If no word is ready when a fetch is due, `cfg_repeat`=1 keeps the last sample of the affected channel(s) and `cfg_repeat`=0 sends zero samples.
- R10: Every underflow sets the sticky `underrun` flag. `urun_clr` clears it, and a new underflow in the same cycle wins over the clear. `underrun_irq` equals `underrun` AND `urun_ie`.
- R11: After reset, `sd`=0, `tx_req`=1, `fifo_full`=0, `underrun`=0 and `underrun_irq`=0.
- R12: `sd` changes only in the cycle after a bit strobe. A `frame_stb` restarts the frame at slot bit 0 from any position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word |
| thresh | input | 5 | Refill request level |
| fifo_full | output | 1 | FIFO holds its full depth |
| tx_req | output | 1 | Refill request, level <= thresh |
| bit_stb | input | 1 | One-cycle strobe per bit period |
| frame_stb | input | 1 | With bit_stb: first bit of a frame |
| cfg_msbj | input | 1 | 0 = I2S, 1 = MSB-justified |
| cfg_rfirst | input | 1 | 0 = left slot first, 1 = right first |
| cfg_stereo | input | 1 | 0 = mono, 1 = stereo |
| cfg_packed | input | 1 | Two 16-bit samples per word (stereo) |
| cfg_size | input | 3 | Sample width code |
| cfg_repeat | input | 1 | Underflow: 1 = repeat, 0 = zero |
| urun_clr | input | 1 | Clear the underrun flag |
| urun_ie | input | 1 | Underrun interrupt enable |
| sd | output | 1 | Serial data out |
| underrun | output | 1 | Sticky underrun flag |
| underrun_irq | output | 1 | Gated underrun interrupt |

## Verification
The properties assume that bit strobes come at least four system clocks apart, which gives the FIFO read pipeline time to refill between fetches. They also assume that `frame_stb` is high only together with `bit_stb`, and that the configuration inputs stay fixed within a frame. The stimulus spaces its strobes five cycles apart and raises `frame_stb` only on the first strobe of a frame. It changes configuration only between frames and writes words several cycles before the frame that uses them.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int SLOT_LEN  = 32;
  localparam int FRAME_LEN = 2 * SLOT_LEN;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int SMP_W     = 24;
  localparam int WID_W     = 5;

  typedef enum logic [2:0] {
    SZ_8  = 3'd0,
    SZ_16 = 3'd1,
    SZ_18 = 3'd2,
    SZ_20 = 3'd3,
    SZ_24 = 3'd4
  } smp_size_e;

  // Width in bits for a size code; reserved codes fall back to the widest.
  function automatic logic [WID_W-1:0] size_bits(input logic [2:0] code);
    case (code)
      SZ_8:    size_bits = WID_W'(8);
      SZ_16:   size_bits = WID_W'(16);
      SZ_18:   size_bits = WID_W'(18);
      SZ_20:   size_bits = WID_W'(20);
      default: size_bits = WID_W'(24);
    endcase
  endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic [LW-1:0] thresh,
  output logic [DW-1:0] head_data,
  output logic          head_vld,
  output logic          full,
  output logic          req,
  output logic [LW-1:0] level
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata;
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] mem_cnt, cnt, cnt_nxt;
  logic          rd_pend;
  logic          push_ok, pop_ok, rd_en;

  assign push_ok = push && (cnt != LW'(DEPTH));
  assign pop_ok  = pop && head_vld;
  assign rd_en   = (mem_cnt != '0) && !rd_pend && (!head_vld || pop_ok);
  assign cnt_nxt = cnt + LW'(push_ok) - LW'(pop_ok);

  // storage array: synchronous write, registered read
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      mem_cnt  <= '0;
      cnt      <= '0;
      rd_pend  <= 1'b0;
      head_vld <= 1'b0;
      req      <= 1'b1;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (rd_en)   rptr <= rptr + 1'b1;
      mem_cnt <= mem_cnt + LW'(push_ok) - LW'(rd_en);
      cnt     <= cnt_nxt;
      rd_pend <= rd_en;
      if (rd_pend)     head_vld <= 1'b1;
      else if (pop_ok) head_vld <= 1'b0;
      req <= (cnt_nxt <= thresh);
    end
  end

  assign head_data = rdata;
  assign full      = (cnt == LW'(DEPTH));
  assign level     = cnt;

endmodule

// File: rtl/i2s_tx_slot_loader.sv
module i2s_tx_slot_loader
  import i2s_tx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             frame_stb,
  input  logic             cfg_stereo,
  input  logic             cfg_packed,
  input  logic             cfg_rfirst,
  input  logic             cfg_repeat,
  input  logic             urun_clr,
  input  logic             urun_ie,
  input  logic [DW-1:0]    head_data,
  input  logic             head_vld,
  output logic             pop,
  output logic             uflow,
  output logic [POS_W-1:0] pos_nxt,
  output logic [SMP_W-1:0] l_nxt,
  output logic [SMP_W-1:0] r_nxt,
  output logic             underrun,
  output logic             underrun_irq
);

  localparam int HALF = SMP_W - 16;

  logic [POS_W-1:0] pos_q;
  logic [SMP_W-1:0] l_q, r_q;
  logic             per_slot, slot_start, need_fetch, slot_right, urun_nxt;

  assign pos_nxt    = frame_stb ? '0 : pos_q + 1'b1;
  assign per_slot   = cfg_stereo && !cfg_packed;
  assign slot_start = (pos_nxt[POS_W-2:0] == '0);
  assign need_fetch = bit_stb && slot_start && (per_slot || !pos_nxt[POS_W-1]);
  assign slot_right = pos_nxt[POS_W-1] ^ cfg_rfirst;
  assign pop        = need_fetch && head_vld;
  assign uflow      = need_fetch && !head_vld;

  always_comb begin
    l_nxt = l_q;
    r_nxt = r_q;
    if (pop) begin
      if (!cfg_stereo) begin
        l_nxt = head_data[SMP_W-1:0];
        r_nxt = head_data[SMP_W-1:0];
      end else if (cfg_packed) begin
        l_nxt = {{HALF{1'b0}}, head_data[15:0]};
        r_nxt = {{HALF{1'b0}}, head_data[31:16]};
      end else if (slot_right) begin
        r_nxt = head_data[SMP_W-1:0];
      end else begin
        l_nxt = head_data[SMP_W-1:0];
      end
    end else if (uflow && !cfg_repeat) begin
      if (per_slot && slot_right)       r_nxt = '0;
      else if (per_slot)                l_nxt = '0;
      else begin
        l_nxt = '0;
        r_nxt = '0;
      end
    end
  end

  assign urun_nxt = uflow ? 1'b1 : (urun_clr ? 1'b0 : underrun);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q        <= '1;
      l_q          <= '0;
      r_q          <= '0;
      underrun     <= 1'b0;
      underrun_irq <= 1'b0;
    end else begin
      if (bit_stb) pos_q <= pos_nxt;
      l_q          <= l_nxt;
      r_q          <= r_nxt;
      underrun     <= urun_nxt;
      underrun_irq <= urun_nxt && urun_ie;
    end
  end

endmodule

// File: rtl/i2s_tx_bit_emitter.sv
module i2s_tx_bit_emitter
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             cfg_msbj,
  input  logic             cfg_rfirst,
  input  logic [WID_W-1:0] width,
  input  logic [POS_W-1:0] pos_nxt,
  input  logic [SMP_W-1:0] l_nxt,
  input  logic [SMP_W-1:0] r_nxt,
  output logic             sd
);

  localparam int IW = $clog2(SLOT_LEN) + 1;

  logic [SMP_W-1:0]    smp;
  logic [SLOT_LEN-1:0] aligned;
  logic [IW-1:0]       shamt, idx, bpos;
  logic                bit_val;

  assign smp     = (pos_nxt[POS_W-1] ^ cfg_rfirst) ? r_nxt : l_nxt;
  assign shamt   = IW'(SLOT_LEN) - IW'(width);
  assign aligned = {{(SLOT_LEN-SMP_W){1'b0}}, smp} << shamt;
  assign bpos    = {1'b0, pos_nxt[POS_W-2:0]};
  assign idx     = cfg_msbj ? (IW'(SLOT_LEN - 1) - bpos) : (IW'(SLOT_LEN) - bpos);
  assign bit_val = idx[IW-1] ? 1'b0 : aligned[idx[IW-2:0]];

  always_ff @(posedge clk) begin
    if (rst)          sd <= 1'b0;
    else if (bit_stb) sd <= bit_val;
  end

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic [LW-1:0] thresh,
  output logic          fifo_full,
  output logic          tx_req,
  input  logic          bit_stb,
  input  logic          frame_stb,
  input  logic          cfg_msbj,
  input  logic          cfg_rfirst,
  input  logic          cfg_stereo,
  input  logic          cfg_packed,
  input  logic [2:0]    cfg_size,
  input  logic          cfg_repeat,
  input  logic          urun_clr,
  input  logic          urun_ie,
  output logic          sd,
  output logic          underrun,
  output logic          underrun_irq
);

  logic [31:0]      head_data;
  logic             head_vld, fetch_pop, fetch_uflow;
  logic [LW-1:0]    level;
  logic [POS_W-1:0] pos_nxt;
  logic [SMP_W-1:0] l_nxt, r_nxt;
  logic [WID_W-1:0] eff_width;

  assign eff_width = (cfg_stereo && cfg_packed) ? WID_W'(16) : size_bits(cfg_size);

  i2s_tx_fifo #(.DW(32), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(wr_en), .wdata(wr_data), .pop(fetch_pop),
    .thresh(thresh), .head_data(head_data), .head_vld(head_vld),
    .full(fifo_full), .req(tx_req), .level(level)
  );

  i2s_tx_slot_loader #(.DW(32)) loader_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .frame_stb(frame_stb),
    .cfg_stereo(cfg_stereo), .cfg_packed(cfg_packed), .cfg_rfirst(cfg_rfirst),
    .cfg_repeat(cfg_repeat), .urun_clr(urun_clr), .urun_ie(urun_ie),
    .head_data(head_data), .head_vld(head_vld), .pop(fetch_pop),
    .uflow(fetch_uflow), .pos_nxt(pos_nxt), .l_nxt(l_nxt), .r_nxt(r_nxt),
    .underrun(underrun), .underrun_irq(underrun_irq)
  );

  i2s_tx_bit_emitter emitter_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .cfg_msbj(cfg_msbj),
    .cfg_rfirst(cfg_rfirst), .width(eff_width), .pos_nxt(pos_nxt),
    .l_nxt(l_nxt), .r_nxt(r_nxt), .sd(sd)
  );

endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_stb,
  input logic          frame_stb,
  input logic          cfg_msbj,
  input logic          sd,
  input logic          underrun,
  input logic          underrun_irq,
  input logic          urun_clr,
  input logic          urun_ie,
  input logic          pop,
  input logic          head_vld,
  input logic          uflow,
  input logic          fifo_full,
  input logic          tx_req,
  input logic [LW-1:0] level,
  input logic [LW-1:0] thresh
);

  // R1
  pop_valid_chk: assert property (@(posedge clk) disable iff (rst) pop |-> head_vld);

  // R1
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !pop) |=> fifo_full);

  // R2
  req_level_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req == (level <= thresh));

  // R4
  i2s_lead_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && frame_stb && !cfg_msbj) |=> !sd);

  // R10
  underrun_set_chk: assert property (@(posedge clk) disable iff (rst) uflow |=> underrun);

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun && !urun_clr) |=> underrun);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst) !urun_ie |=> !underrun_irq);

  // R12
  sd_hold_chk: assert property (@(posedge clk) disable iff (rst) !bit_stb |=> $stable(sd));

endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk #(.LW(LW)) chk_i (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .frame_stb(frame_stb),
  .cfg_msbj(cfg_msbj), .sd(sd), .underrun(underrun), .underrun_irq(underrun_irq),
  .urun_clr(urun_clr), .urun_ie(urun_ie), .pop(fetch_pop), .head_vld(head_vld),
  .uflow(fetch_uflow), .fifo_full(fifo_full), .tx_req(tx_req), .level(level),
  .thresh(thresh)
);

// File: tb/i2s_tx_serializer_tb_top.sv
module i2s_tx_serializer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int LW         = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [LW-1:0] thresh = LW'(3);
  logic          fifo_full, tx_req, sd, underrun, underrun_irq;
  logic          bit_stb = 1'b0, frame_stb = 1'b0;
  logic          cfg_msbj = 1'b0, cfg_rfirst = 1'b0, cfg_stereo = 1'b1, cfg_packed = 1'b0;
  logic [2:0]    cfg_size = 3'd1;
  logic          cfg_repeat = 1'b1, urun_clr = 1'b0, urun_ie = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_tx_serializer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .thresh(thresh),
    .fifo_full(fifo_full), .tx_req(tx_req), .bit_stb(bit_stb), .frame_stb(frame_stb),
    .cfg_msbj(cfg_msbj), .cfg_rfirst(cfg_rfirst), .cfg_stereo(cfg_stereo),
    .cfg_packed(cfg_packed), .cfg_size(cfg_size), .cfg_repeat(cfg_repeat),
    .urun_clr(urun_clr), .urun_ie(urun_ie), .sd(sd), .underrun(underrun),
    .underrun_irq(underrun_irq)
  );

  typedef struct packed {
    logic        msbj;
    logic        rfirst;
    logic        stereo;
    logic        pk;
    logic [2:0]  size;
    logic [1:0]  nw;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [23:0] el;
    logic [23:0] er;
    logic [4:0]  w;
  } vec_t;

  localparam int NV = 7;
  // R3 R4 R5 R6 R7 R8: stimulus words and the samples each slot must carry
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 2'd2, 32'h0000A5C3, 32'h00001234, 24'h00A5C3, 24'h001234, 5'd16},
    '{1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 2'd2, 32'hFF800001, 32'h00ABCDEF, 24'h800001, 24'hABCDEF, 5'd24},
    '{1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 2'd2, 32'h00025555, 32'h0001ABCD, 24'h01ABCD, 24'h025555, 5'd18},
    '{1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 2'd1, 32'h000F0F0F, 32'h00000000, 24'h0F0F0F, 24'h0F0F0F, 5'd20},
    '{1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 2'd1, 32'hBEEF1234, 32'h00000000, 24'h001234, 24'h00BEEF, 5'd16},
    '{1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 2'd2, 32'h000001A5, 32'h0000003C, 24'h0000A5, 24'h00003C, 5'd8},
    '{1'b1, 1'b1, 1'b1, 1'b0, 3'd7, 2'd2, 32'h00C00003, 32'h00000001, 24'h000001, 24'hC00003, 5'd24}
  };

  // Expected 64-bit frame, index 0 = first bit sent after the frame strobe
  function automatic logic [63:0] exp_frame(input logic [23:0] l, input logic [23:0] r,
                                            input int w, input bit msbj, input bit rfirst);
    logic [63:0] f = '0;
    for (int s = 0; s < 2; s++) begin
      logic [23:0] smp = ((s == 1) ^ rfirst) ? r : l;
      for (int b = 0; b < 32; b++) begin
        int k = msbj ? b : b - 1;
        f[s*32 + b] = (k >= 0 && k < w) ? smp[w-1-k] : 1'b0;
      end
    end
    return f;
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(input bit first, output logic s);
    @(negedge clk);
    bit_stb = 1'b1;
    frame_stb = first;
    @(negedge clk);
    bit_stb = 1'b0;
    frame_stb = 1'b0;
    s = sd;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(output logic [63:0] f);
    for (int i = 0; i < 64; i++) begin
      logic s;
      strobe(i == 0, s);
      f[i] = s;
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] fr;
    logic s0, s1;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 sd", 64'(sd), 64'd0);
    chk("R11 tx_req", 64'(tx_req), 64'd1);
    chk("R11 fifo_full", 64'(fifo_full), 64'd0);
    chk("R11 underrun", 64'(underrun), 64'd0);
    chk("R11 underrun_irq", 64'(underrun_irq), 64'd0);

    // Table of framing vectors
    for (int v = 0; v < NV; v++) begin
      cfg_msbj   = VECS[v].msbj;
      cfg_rfirst = VECS[v].rfirst;
      cfg_stereo = VECS[v].stereo;
      cfg_packed = VECS[v].pk;
      cfg_size   = VECS[v].size;
      push(VECS[v].w0);
      if (VECS[v].nw == 2'd2) push(VECS[v].w1);
      settle();
      run_frame(fr);
      chk($sformatf("R3/R4/R5/R6/R7/R8 vector %0d", v), fr,
          exp_frame(VECS[v].el, VECS[v].er, int'(VECS[v].w), VECS[v].msbj, VECS[v].rfirst));
    end
    chk("R10 no underrun after table", 64'(underrun), 64'd0);

    // R9 repeat policy
    cfg_msbj = 1'b1; cfg_rfirst = 1'b0; cfg_stereo = 1'b1; cfg_packed = 1'b0;
    cfg_size = 3'd1; cfg_repeat = 1'b1;
    push(32'h1111); push(32'h2222);
    settle();
    run_frame(fr);
    chk("R9 full frame before underflow", fr, exp_frame(24'h1111, 24'h2222, 16, 1'b1, 1'b0));
    push(32'h3333);
    settle();
    run_frame(fr);
    chk("R9 repeat keeps right sample", fr, exp_frame(24'h3333, 24'h2222, 16, 1'b1, 1'b0));

    // R10 sticky flag and interrupt gating
    chk("R10 underrun set", 64'(underrun), 64'd1);
    chk("R10 irq masked", 64'(underrun_irq), 64'd0);
    urun_ie = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 irq enabled", 64'(underrun_irq), 64'd1);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    @(negedge clk);
    chk("R10 clear flag", 64'(underrun), 64'd0);
    chk("R10 clear irq", 64'(underrun_irq), 64'd0);

    // R9 zero policy
    cfg_repeat = 1'b0;
    push(32'h4444);
    settle();
    run_frame(fr);
    chk("R9 zero policy right slot", fr, exp_frame(24'h4444, 24'h0, 16, 1'b1, 1'b0));
    run_frame(fr);
    chk("R9 zero policy empty frame", fr, 64'd0);

    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;

    // R1 / R2 fill to full, threshold request
    for (int i = 0; i < DEPTH; i++) begin
      push(32'(i + 1));
      @(negedge clk);
      chk($sformatf("R2 tx_req at level %0d", i + 1), 64'(tx_req), 64'((i + 1) <= 3));
      if (i == DEPTH - 2) chk("R1 not full at depth-1", 64'(fifo_full), 64'd0);
    end
    chk("R1 full at depth", 64'(fifo_full), 64'd1);
    push(32'hDEAD);
    chk("R1 still full after dropped write", 64'(fifo_full), 64'd1);
    for (int f = 0; f < DEPTH / 2; f++) begin
      run_frame(fr);
      chk($sformatf("R1 drain order frame %0d", f), fr,
          exp_frame(24'(2*f + 1), 24'(2*f + 2), 16, 1'b1, 1'b0));
    end
    chk("R2 tx_req after drain", 64'(tx_req), 64'd1);
    run_frame(fr);
    chk("R1 dropped write never sent", fr, 64'd0);
    chk("R10 underrun after drain", 64'(underrun), 64'd1);

    // R12 hold between strobes and resynchronisation
    push(32'hAAAA); push(32'hBBBB);
    settle();
    @(negedge clk);
    bit_stb = 1'b1; frame_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0; frame_stb = 1'b0;
    s0 = sd;
    repeat (3) @(negedge clk);
    s1 = sd;
    chk("R12 sd held between strobes", 64'(s1), 64'(s0));
    for (int i = 0; i < 9; i++) strobe(1'b0, s0);
    run_frame(fr);
    chk("R12 frame strobe restarts frame", fr, exp_frame(24'hBBBB, 24'h0, 16, 1'b1, 1'b0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule